// File: doc/BRIEF.md
# Multichannel Transmit Service Request Generator

This block decides when the host must service the transmit side of a group of serial channels. Each channel has a small byte FIFO feeding a character shifter. Line timing is reduced to a per-channel pulse that marks the end of the current character. Each channel carries two request-enable bits. One asks for service whenever its FIFO has run empty. The other asks for service once the shifter has gone idle after the last character, so the host knows the line is quiet and can safely reconfigure the channel.

Requesting channels are arbitrated round-robin. One service episode is presented at a time, with the channel number and the kind of request. During the episode the host may write a bounded number of bytes into that channel's FIFO. The episode ends with a done strobe. If both enable bits are set, the empty-FIFO request for a given drain always comes first. Further empty-FIFO requests can follow before the drain request arrives. Clearing a channel's enable bits withdraws it from arbitration.

Top module: `tx_svc_req_gen`

## Requirements
- R1: After reset no request is presented (`svc_req`=0), every shifter is idle (`tx_busy`=0) and no overflow flag is set.
- R2: A channel with `en_fifo` set and an empty FIFO requests service of kind 0 (`svc_kind`=0), unless that same empty state has already been acknowledged.
- R3: When a channel's shifter finishes a character and its FIFO is empty, a sticky drain flag is set. With `en_drain` set, this flag produces a request of kind 1. The flag is cleared when that request is acknowledged or when a byte is written to the channel.
- R4: If a channel has both kinds pending, kind 0 is presented first, so the empty-FIFO request for a drain always precedes the drain request.
- R5: Writing bytes re-arms the empty-FIFO request. A channel that received data in an episode therefore requests kind 0 again when its FIFO next runs empty, even while its last character is still being shifted.
- R6: Once presented, a request keeps `svc_req`, `svc_ch` and `svc_kind` unchanged until `svc_done`. Only one request is presented at a time.
- R7: Grants are round-robin. The search starts at the channel after the last one granted, and starts at channel 0 after reset.
- R8: A write (`push_valid`) during an episode goes to channel `svc_ch`. At most 8 bytes are accepted per episode. Further writes are dropped and set that channel's sticky `ovf` bit.
- R9: Bytes leave a channel in the order written. `tx_byte` for channel i (bits i*8 +: 8) holds the character being shifted while `tx_busy[i]` is 1. Each `char_done[i]` pulse retires it.
- R10: A channel whose enable bits are clear raises no request. Setting `en_fifo` again while its FIFO is empty yields a fresh kind-0 request.
- R11: `push_valid` while no request is presented is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_fifo | input | 8 | Per-channel empty-FIFO request enable |
| en_drain | input | 8 | Per-channel transmitter-drained request enable |
| char_done | input | 8 | Per-channel end-of-character pulse from the line |
| push_valid | input | 1 | Host byte write to the serviced channel |
| push_data | input | 8 | Byte written |
| svc_done | input | 1 | Host end-of-service strobe |
| svc_req | output | 1 | A service request is presented |
| svc_ch | output | 3 | Number of the channel being serviced |
| svc_kind | output | 1 | 0 = FIFO empty, 1 = transmitter drained |
| tx_busy | output | 8 | Per-channel shifter holds a character |
| tx_byte | output | 64 | Per-channel character in the shifter |
| ovf | output | 8 | Per-channel sticky dropped-write flag |

## Verification
The hardest situation to reach is a single channel holding a pending empty-FIFO request and a drain request at the same time. A further empty-FIFO request must also slip in between them. The stimulus enables both kinds on one channel and writes two bytes in one episode, so the FIFO is still non-empty when the acknowledgement arrives. The line pulses arrive slowly enough that a second empty-FIFO request is raised while the last character is still in the shifter. The bench expects the kinds in the order 0, 0, 1. A separate episode writes ten bytes to force the per-episode cap and the overflow flag.

// File: rtl/tx_svc_req_gen.sv
module tx_svc_req_gen #(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_fifo,
  input  logic [NCH-1:0]    en_drain,
  input  logic [NCH-1:0]    char_done,
  input  logic              push_valid,
  input  logic [DW-1:0]     push_data,
  input  logic              svc_done,
  output logic              svc_req,
  output logic [$clog2(NCH)-1:0] svc_ch,
  output logic              svc_kind,
  output logic [NCH-1:0]    tx_busy,
  output logic [NCH*DW-1:0] tx_byte,
  output logic [NCH-1:0]    ovf
);
  localparam int CHW = $clog2(NCH);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;

  logic [DW-1:0] mem [NCH][DEPTH];
  logic [PW-1:0] wp [NCH];
  logic [PW-1:0] rp [NCH];
  logic [CW-1:0] cnt [NCH];
  logic [DW-1:0] cur [NCH];
  logic [NCH-1:0] fe_done, dr_flag, fe_req, dr_req, any_req;
  logic [CHW-1:0] last, pick;
  logic [CW-1:0]  ep_cnt;
  logic           hit, push_try, push_ok, push_ref, ack_fe, ack_dr;

  assign fe_req  = en_fifo & ~fe_done & empty_vec();
  assign dr_req  = en_drain & dr_flag;
  assign any_req = fe_req | dr_req;

  function automatic logic [NCH-1:0] empty_vec();
    for (int i = 0; i < NCH; i++) empty_vec[i] = (cnt[i] == '0);
  endfunction

  assign push_try = svc_req && push_valid;
  assign push_ok  = push_try && ep_cnt < CW'(DEPTH) && cnt[svc_ch] < CW'(DEPTH);
  assign push_ref = push_try && !push_ok;
  assign ack_fe   = svc_req && svc_done && !svc_kind;
  assign ack_dr   = svc_req && svc_done && svc_kind;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = (int'(last) + 1 + k) % NCH;
      if (!hit && any_req[j]) begin
        hit  = 1'b1;
        pick = CHW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_req  <= 1'b0;
      svc_ch   <= '0;
      svc_kind <= 1'b0;
      last     <= CHW'(NCH - 1);
      ep_cnt   <= '0;
    end else if (!svc_req) begin
      if (hit) begin
        svc_req  <= 1'b1;
        svc_ch   <= pick;
        svc_kind <= ~fe_req[pick];
        last     <= pick;
      end
      ep_cnt <= '0;
    end else begin
      if (push_ok) ep_cnt <= ep_cnt + 1'b1;
      if (svc_done) svc_req <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic push_i, pop_i;
    assign push_i = push_ok && svc_ch == CHW'(i);
    assign pop_i  = cnt[i] != '0 && (!tx_busy[i] || char_done[i]);
    assign tx_byte[i*DW +: DW] = cur[i];

    always_ff @(posedge clk) begin
      if (push_i) mem[i][wp[i]] <= push_data;
      if (!rst_n) begin
        wp[i] <= '0; rp[i] <= '0; cnt[i] <= '0; cur[i] <= '0;
        tx_busy[i] <= 1'b0; fe_done[i] <= 1'b0; dr_flag[i] <= 1'b0; ovf[i] <= 1'b0;
      end else begin
        if (push_i) wp[i] <= wp[i] + 1'b1;
        if (pop_i) rp[i] <= rp[i] + 1'b1;
        cnt[i] <= cnt[i] + CW'(push_i) - CW'(pop_i);
        if (pop_i) begin
          tx_busy[i] <= 1'b1;
          cur[i]     <= mem[i][rp[i]];
        end else if (char_done[i]) begin
          tx_busy[i] <= 1'b0;
        end
        if (push_i || (ack_dr && svc_ch == CHW'(i))) dr_flag[i] <= 1'b0;
        else if (tx_busy[i] && char_done[i] && !pop_i) dr_flag[i] <= 1'b1;
        if (push_i || cnt[i] != '0 || !en_fifo[i]) fe_done[i] <= 1'b0;
        else if (ack_fe && svc_ch == CHW'(i)) fe_done[i] <= 1'b1;
        if (push_ref && svc_ch == CHW'(i)) ovf[i] <= 1'b1;
      end
    end

    always_comb AST_FIFO_BOUND: assert (cnt[i] <= CW'(DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(ovf[i])); // R8
  end

  always_comb AST_EPISODE_CAP: assert (ep_cnt <= CW'(DEPTH)); // R8
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req && !svc_done |=> svc_req && $stable(svc_ch) && $stable(svc_kind)); // R6
  AST_FE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req) && !svc_kind |-> cnt[svc_ch] == '0); // R2
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req) && svc_kind |-> !tx_busy[svc_ch] && cnt[svc_ch] == '0); // R3
  AST_DRAIN_AFTER_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req) && svc_kind |-> !fe_req[svc_ch]); // R4
endmodule

// File: tb/tb_tx_svc_req_gen.sv
module tb_tx_svc_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] en_fifo = 0, en_drain = 0, char_done = 0;
  logic push_valid = 0, svc_done = 0;
  logic [7:0] push_data = 0;
  logic svc_req, svc_kind;
  logic [2:0] svc_ch;
  logic [7:0] tx_busy, ovf;
  logic [63:0] tx_byte;

  int tests = 0, fails = 0;
  bit [7:0] exp_q [NCH][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_svc_req_gen dut (.clk, .rst_n, .en_fifo, .en_drain, .char_done, .push_valid,
    .push_data, .svc_done, .svc_req, .svc_ch, .svc_kind, .tx_busy, .tx_byte, .ovf);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: line model pulses char_done every 6 cycles and pops the scoreboard
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      for (int i = 0; i < NCH; i++) begin
        if (ph % 6 == 0 && rst_n && tx_busy[i]) begin
          if (exp_q[i].size() == 0) chk(0, "R9 extra byte", tx_byte[i*8 +: 8], 0);
          else begin
            bit [7:0] e;
            e = exp_q[i].pop_front();
            chk(tx_byte[i*8 +: 8] == e, "R9 byte order", tx_byte[i*8 +: 8], e);
          end
          char_done[i] = 1;
        end else char_done[i] = 0;
      end
    end
  end

  task automatic serve(input int ch, input bit kind, input int n, input string req);
    int t = 0;
    while (!svc_req && t < 400) begin @(negedge clk); t++; end
    chk(svc_req == 1, {req, " request"}, svc_req, 1);
    chk(svc_ch == ch[2:0], {req, " channel"}, svc_ch, ch);
    chk(svc_kind == kind, {req, " kind"}, svc_kind, kind);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      push_valid = 1;
      push_data  = 8'(8'h20 + ch * 16 + k);
      if (k < 8) exp_q[ch].push_back(push_data);
    end
    @(negedge clk); push_valid = 0; svc_done = 1;
    @(negedge clk); svc_done = 0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (svc_req) seen = 1; end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(svc_req == 0, "R1 no request", svc_req, 0);
    chk(tx_busy == 0, "R1 shifters idle", tx_busy, 0);
    chk(ovf == 0, "R1 no overflow", ovf, 0);
    quiet(5, "R10 nothing enabled");

    // R11: writes outside an episode are ignored
    for (int k = 0; k < 3; k++) begin @(negedge clk); push_valid = 1; push_data = 8'hA5; end
    @(negedge clk); push_valid = 0;
    repeat (10) @(negedge clk);
    chk(tx_busy == 0, "R11 push ignored", tx_busy, 0);

    // R2 / R5: empty request, then a repeat once the data has been pulled
    en_fifo[3] = 1;
    serve(3, 0, 3, "R2 first empty");
    serve(3, 0, 0, "R5 repeat empty");
    quiet(40, "R3 no drain without enable");

    // R3 / R4 / R5: both enables, order 0,0,1
    en_fifo[5] = 1; en_drain[5] = 1;
    serve(5, 0, 2, "R4 empty first");
    serve(5, 0, 0, "R5 empty again");
    serve(5, 1, 0, "R3 drain");
    quiet(30, "R3 drain flag cleared");

    // R7: round-robin after last grant (5)
    en_fifo[1] = 1; en_fifo[2] = 1; en_fifo[6] = 1;
    serve(6, 0, 0, "R7 rr first");
    serve(1, 0, 0, "R7 rr second");
    serve(2, 0, 0, "R7 rr third");
    quiet(10, "R2 acknowledged stays quiet");

    // R10: disable then re-enable
    en_fifo[1] = 0;
    quiet(10, "R10 disabled");
    en_fifo[1] = 1;
    serve(1, 0, 0, "R10 fresh request");

    // R8: ten writes, eight accepted, overflow on channel 2
    en_fifo[2] = 0; @(negedge clk); en_fifo[2] = 1;
    serve(2, 0, 10, "R8 episode");
    chk(ovf == 8'b0000_0100, "R8 overflow flag", ovf, 8'h04);
    serve(2, 0, 0, "R5 after overflow");
    begin
      int t = 0;
      while ((tx_busy != 0 || exp_q[2].size() != 0) && t < 2000) begin @(negedge clk); t++; end
    end
    chk(exp_q[2].size() == 0, "R9 all bytes sent", exp_q[2].size(), 0);
    chk(tx_busy == 0, "R9 shifters idle", tx_busy, 0);
    chk(ovf == 8'b0000_0100, "R8 overflow sticky", ovf, 8'h04);
    quiet(10, "R2 idle at end");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule